// File: doc/BRIEF.md
# Lockable Backup Watchdog Timer

This block is a backup watchdog for a supervisor-controlled system. A 16-bit control word turns the watchdog on. The same word picks which of three low-power states (stop, wait, doze) pause the countdown. The control word takes exactly one write after power-on. From then on it is frozen: later bus writes and warm resets leave it as it is. Only a power-on reset puts it back to its default.

A reload register holds the timeout length. Once enabled, a down-counter starts from that length and steps down by one each clock. When it reaches zero it raises a single-cycle timeout pulse and starts again. Software keeps the timeout away by writing a two-word key sequence to a service location, which restarts the countdown. A reset controller outside this block acts on the timeout pulse.

Top module: `wdog_ctl`

## Requirements
- R1: After power-on reset, address 0 (control) reads 0x0002, address 2 (live count) reads 0, address 1 (reload) reads its reset value with all CNT_W bits set, and the timeout pulse is low.
- R2: The first supervisor write to address 0 after power-on reset is taken. Every later write to address 0 leaves the control word unchanged until the next power-on reset.
- R3: A warm reset keeps the control word, its lock and the reload value. It clears the count, and an enabled counter reloads from the reload value on the first clock after the warm reset ends. Power-on reset brings the control word back to 0x0002.
- R4: Control bit 1 always reads 1 and bits 15 to 5 always read 0, whatever was written to them.
- R5: While control bit 0 (enable) is 0, the count stays 0 and no timeout pulse appears.
- R6: When enable becomes 1, the counter loads the reload value (the low CNT_W bits of the last write to address 1) on the next clock. It then drops by one on each clock while not paused.
- R7: The clock edge that finds the count at 0 while running raises the timeout pulse for exactly one cycle and reloads the count.
- R8: Control bits 4, 3 and 2 pause the count while mode_stop, mode_wait and mode_doze are high, respectively. If a mode's bit is 0, counting goes on in that mode.
- R9: Accesses with bus_super low have no effect, and their reads return 0.
- R10: Writing 0x5555 and then, as the next write to address 3, 0xAAAA reloads the count from the reload value, even while paused. Any other write in between cancels the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| wrst_n | input | 1 | Warm reset, active low, clears only the counting state |
| bus_addr | input | AW | Register address: 0 control, 1 reload, 2 count, 3 service |
| bus_we | input | 1 | Write strobe for a full-word write |
| bus_wdata | input | DW | Write data |
| bus_super | input | 1 | High for a supervisor access |
| mode_stop | input | 1 | Device is in stop mode |
| mode_wait | input | 1 | Device is in wait mode |
| mode_doze | input | 1 | Device is in doze mode |
| bus_rdata | output | DW | Read data for bus_addr |
| tmo_pulse | output | 1 | One-cycle timeout pulse |

## Verification
The bench builds the block with CNT_W set to 12, narrower than the 16-bit bus. This exercises truncation of reload writes, and the reset reload value reads back as 0x0FFF, not 0xFFFF. The bench programs a reload value of 4. A full countdown, the timeout pulse and the reload that follows it then fit in a few cycles. The one-write lock, the mode pauses, the service key and both kinds of reset can therefore each be checked cycle by cycle against a single known count.

// File: rtl/wdog_ctl.sv
module wdog_ctl #(
  parameter int DW    = 16,
  parameter int CNT_W = 16,
  parameter int AW    = 2,
  parameter logic [CNT_W-1:0] MOD_RST = '1
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          wrst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_super,
  input  logic          mode_stop,
  input  logic          mode_wait,
  input  logic          mode_doze,
  output logic [DW-1:0] bus_rdata,
  output logic          tmo_pulse
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_MOD  = AW'(1);
  localparam logic [AW-1:0] A_CNT  = AW'(2);
  localparam logic [AW-1:0] A_SVC  = AW'(3);
  localparam logic [DW-1:0] KEY1   = DW'(16'h5555);
  localparam logic [DW-1:0] KEY2   = DW'(16'hAAAA);

  logic en_q, hs_q, hw_q, hd_q, lock_q;
  logic [CNT_W-1:0] mod_q, cnt_q;
  logic armed_q, svc_arm_q;

  wire rst_n    = por_n & wrst_n;
  wire wr_ok    = bus_we & bus_super;
  wire wr_ctrl  = wr_ok & (bus_addr == A_CTRL);
  wire wr_mod   = wr_ok & (bus_addr == A_MOD);
  wire svc_hit  = wr_ok & (bus_addr == A_SVC);
  wire svc_fire = svc_hit & svc_arm_q & (bus_wdata == KEY2);
  wire frozen   = (hs_q & mode_stop) | (hw_q & mode_wait) | (hd_q & mode_doze);

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      {en_q, hs_q, hw_q, hd_q, lock_q} <= '0;
      mod_q <= MOD_RST;
    end else begin
      if (wr_ctrl && !lock_q) begin
        en_q   <= bus_wdata[0];
        hd_q   <= bus_wdata[2];
        hw_q   <= bus_wdata[3];
        hs_q   <= bus_wdata[4];
        lock_q <= 1'b1;
      end
      if (wr_mod) mod_q <= bus_wdata[CNT_W-1:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) svc_arm_q <= 1'b0;
    else if (svc_hit) svc_arm_q <= (bus_wdata == KEY1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed_q   <= 1'b0;
      cnt_q     <= '0;
      tmo_pulse <= 1'b0;
    end else begin
      tmo_pulse <= 1'b0;
      if (!armed_q) begin
        if (en_q) begin
          armed_q <= 1'b1;
          cnt_q   <= mod_q;
        end
      end else if (svc_fire) begin
        cnt_q <= mod_q;
      end else if (!frozen) begin
        if (cnt_q == '0) begin
          cnt_q     <= mod_q;
          tmo_pulse <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end

  always_comb begin
    bus_rdata = '0;
    if (bus_super)
      case (bus_addr)
        A_CTRL:  bus_rdata = DW'({hs_q, hw_q, hd_q, 1'b1, en_q});
        A_MOD:   bus_rdata = DW'(mod_q);
        A_CNT:   bus_rdata = DW'(cnt_q);
        default: bus_rdata = '0;
      endcase
  end

  a_r2_lock_holds: assert property (@(posedge clk) disable iff (!por_n)
    lock_q |=> lock_q && $stable({en_q, hs_q, hw_q, hd_q}));

  a_r5_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !tmo_pulse && cnt_q == '0);

  a_r6_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !frozen && !svc_fire && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_pulse && mod_q != '0) |=> !tmo_pulse);

  a_r7_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_pulse) |-> $past(cnt_q) == '0);

  a_r8_pause_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && frozen && !svc_fire) |=> $stable(cnt_q));
endmodule

// File: tb/test_wdog_ctl.sv
`timescale 1ns/10ps
module test_wdog_ctl;
  logic clk = 0, por_n = 0, wrst_n = 0;
  logic [1:0] bus_addr = '0;
  logic bus_we = 0, bus_super = 0;
  logic [15:0] bus_wdata = '0;
  logic mode_stop = 0, mode_wait = 0, mode_doze = 0;
  logic [15:0] bus_rdata;
  logic tmo_pulse;

  int errors = 0, checks = 0;
  bit done = 0;
  int unsigned act_q[$], exp_q[$];
  string tag_q[$];

  wdog_ctl #(.DW(16), .CNT_W(12), .AW(2)) i_wdog_ctl (
    .clk, .por_n, .wrst_n, .bus_addr, .bus_we, .bus_wdata, .bus_super,
    .mode_stop, .mode_wait, .mode_doze, .bus_rdata, .tmo_pulse);

  always #2.5 clk = ~clk;

  task automatic push(int unsigned act, int unsigned exp, string tag);
    act_q.push_back(act); exp_q.push_back(exp); tag_q.push_back(tag);
  endtask

  task automatic chk(logic [1:0] a, int unsigned exp, string tag);
    bus_addr = a; bus_super = 1; #0.1;
    push(bus_rdata, exp, tag);
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d, logic sup);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_super = sup; bus_we = 1;
    @(negedge clk);
    bus_we = 0; bus_super = 1;
  endtask

  initial forever begin
    wait (exp_q.size() != 0);
    checks++;
    if (act_q[0] != exp_q[0]) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag_q[0], act_q[0], exp_q[0]);
    end
    void'(act_q.pop_front()); void'(exp_q.pop_front()); void'(tag_q.pop_front());
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog R1..all actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1; wrst_n = 1;
    @(negedge clk);
    chk(0, 16'h0002, "R1 control reset");
    chk(2, 0, "R1 count reset");
    chk(1, 16'h0FFF, "R1 reload reset");
    push(tmo_pulse, 0, "R1 no pulse");

    bus_super = 0; bus_addr = 0; #0.1;
    push(bus_rdata, 0, "R9 user read");
    wr(1, 16'h0004, 0);
    wr(0, 16'h0001, 0);
    chk(1, 16'h0FFF, "R9 user reload write ignored");
    chk(0, 16'h0002, "R9 user control write ignored");

    wr(1, 16'h0004, 1);
    chk(1, 4, "R6 reload value");
    repeat (4) begin
      @(negedge clk);
      chk(2, 0, "R5 idle count");
      push(tmo_pulse, 0, "R5 idle pulse");
    end

    wr(0, 16'hFFF5, 1);
    chk(0, 16'h0017, "R4 reserved bits");
    chk(2, 0, "R6 not yet loaded");
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(2, 4 - k, "R6 countdown");
      push(tmo_pulse, 0, "R7 no early pulse");
    end
    @(negedge clk);
    push(tmo_pulse, 1, "R7 pulse");
    chk(2, 4, "R7 reload");
    @(negedge clk);
    push(tmo_pulse, 0, "R7 single cycle");
    chk(2, 3, "R6 after reload");

    mode_stop = 1;
    repeat (3) begin
      @(negedge clk);
      chk(2, 3, "R8 stop pause");
    end
    wr(0, 16'h0000, 1);
    chk(0, 16'h0017, "R2 second write ignored");
    wr(0, 16'hFFFF, 1);
    chk(0, 16'h0017, "R2 third write ignored");

    wr(3, 16'h5555, 1); wr(3, 16'h1234, 1); wr(3, 16'hAAAA, 1);
    chk(2, 3, "R10 broken key");
    wr(3, 16'h5555, 0); wr(3, 16'hAAAA, 0);
    chk(2, 3, "R10 user key ignored");
    wr(3, 16'h5555, 1); wr(3, 16'hAAAA, 1);
    chk(2, 4, "R10 key reload");

    mode_stop = 0; mode_wait = 1;
    @(negedge clk); chk(2, 3, "R8 wait runs");
    @(negedge clk); chk(2, 2, "R8 wait runs");
    mode_wait = 0; mode_doze = 1;
    @(negedge clk); chk(2, 2, "R8 doze pause");
    @(negedge clk); chk(2, 2, "R8 doze pause");
    mode_doze = 0;

    wrst_n = 0;
    @(negedge clk);
    chk(2, 0, "R3 warm clears count");
    chk(0, 16'h0017, "R3 warm keeps control");
    push(tmo_pulse, 0, "R3 no pulse in reset");
    @(negedge clk);
    wrst_n = 1;
    @(negedge clk);
    chk(2, 4, "R3 reload after warm");
    chk(1, 4, "R3 reload value kept");
    wr(0, 16'h0000, 1);
    chk(0, 16'h0017, "R3 still locked");

    por_n = 0;
    @(negedge clk);
    chk(0, 16'h0002, "R3 power-on default");
    chk(1, 16'h0FFF, "R3 power-on reload");
    por_n = 1;
    @(negedge clk);
    wr(0, 16'h0000, 1);
    wr(0, 16'h0001, 1);
    chk(0, 16'h0002, "R2 relocked after power-on");
    repeat (3) begin
      @(negedge clk);
      chk(2, 0, "R5 disabled count");
      push(tmo_pulse, 0, "R5 disabled pulse");
    end

    wait (exp_q.size() == 0);
    #1;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule